// File: doc/BRIEF.md
# SDRAM Read-Latency Data Pipeline

This block is the data-path half of a two-bank synchronous DRAM model. A command decoder upstream hands it one-cycle strobes for column read, column write and precharge, together with a bank bit, a column address, a 16-bit write word and one mask bit per byte lane. Each read or write strobe starts a fixed-length burst over consecutive columns. Read words travel through a pipeline whose depth is picked by a programmable latency of one, two or three clocks. The pipeline drives a 16-bit output word and a per-lane output enable.

Write words are stored on the same clock as the strobe that carries them. Masked lanes keep their old byte. During reads, a mask bit takes the matching lane off the bus two clocks later. A new command may cut off a running burst on any cycle. A low clock enable freezes the whole block. A plain behavioural byte-lane array, written so that it maps to block RAM, holds the data.

Top module: `sdram_rdlat_pipe`

## Requirements
- R1: While reset is high, and after it until the first read word emerges, both output enables are low and the output word is zero.
- R2: A read strobe at enabled edge k puts its first word on the bus in the cycle that precedes enabled edge k+L. L is 2 for a latency select of 2, 3 for a select of 3, and 1 for any other select value.
- R3: A burst covers BURST_LEN words on successive enabled edges, one word per edge. The low log2(BURST_LEN) column bits count up and wrap inside the aligned group, so with BURST_LEN 4 a start column of 10 gives 10, 11, 8, 9.
- R4: Write words are taken from the input on the strobe edge and on each later edge of the burst. Mask bit 0 guards bits 7:0 and mask bit 1 guards bits 15:8. A guarded lane keeps its old byte.
- R5: A mask bit sampled at enabled edge m turns its lane's enable off for the cycle after enabled edge m+1. A lane whose enable is low shows zero on the output word.
- R6: A precharge strobe ends a running burst. No word is accessed on the precharge edge or after it, and without a new read the bus is idle from the third enabled edge after the precharge on.
- R7: A read strobe during a read burst restarts the burst at the new address. Words already in flight still come out, followed at once by the new burst.
- R8: A write strobe clears every read word in flight, so both enables are low in the cycle after the write edge.
- R9: A read strobe during a write burst ends the write, and its own edge stores nothing. The enables stay low until the read's latency has elapsed.
- R10: While the clock enable is low, no access happens, commands and masks are ignored, and the pipeline, mask delay and outputs hold.
- R11: When strobes coincide, read wins over write and write wins over precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the block |
| lat_sel | input | 2 | Read latency select (2, 3, else 1) |
| rd_cmd | input | 1 | Column read strobe |
| wr_cmd | input | 1 | Column write strobe |
| pre_cmd | input | 1 | Precharge strobe |
| bank | input | BANK_W | Bank select for the strobe |
| col | input | COL_W | Start column for the strobe |
| mask | input | LANES | Per-lane mask, bit 0 for the low byte |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero in disabled lanes |
| oe | output | LANES | Per-lane output enable |

## Verification
If the burst counter or the wrap arithmetic is wrong, the next word to reach the bus is wrong, at exactly L clocks after the faulty access. A pipeline stage that is skipped or doubled moves the first enable by one cycle. A missed flush shows as enables high in the cycle right after a write strobe. A mask delay off by one clock blanks the wrong word. A stuck freeze path makes the outputs move during a low clock enable. The reference model compares the enables and the data on every cycle, so each of these faults is seen within one cycle of the bus reaching the affected word.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int MAX_LAT = 3;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_READ  = 2'd1,
    SLOT_WRITE = 2'd2
  } slot_e;

  function automatic logic [1:0] lat_decode(input logic [1:0] sel);
    case (sel)
      2'd2:    return 2'd2;
      2'd3:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdp_burst_seq.sv
module sdp_burst_seq
  import sdp_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              pre_cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  output slot_e             slot,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              flush
);

  localparam int OFS_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic              act_q;
  logic              is_rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    if (BURST_LEN > 1) r[OFS_W-1:0] = a[OFS_W-1:0] + 1'b1;
    return r;
  endfunction

  always_comb begin
    slot      = SLOT_IDLE;
    slot_addr = step_addr(addr_q);
    flush     = 1'b0;
    if (cke) begin
      if (rd_cmd) begin
        slot      = SLOT_READ;
        slot_addr = cmd_addr;
      end else if (wr_cmd) begin
        slot      = SLOT_WRITE;
        slot_addr = cmd_addr;
        flush     = 1'b1;
      end else if (!pre_cmd && act_q) begin
        slot = is_rd_q ? SLOT_READ : SLOT_WRITE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (cke) begin
      if (rd_cmd || wr_cmd) begin
        act_q   <= (BURST_LEN > 1);
        is_rd_q <= rd_cmd;
        addr_q  <= cmd_addr;
        rem_q   <= CNT_W'(BURST_LEN - 1);
      end else if (pre_cmd) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        addr_q <= slot_addr;
        rem_q  <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) act_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdp_array.sv
module sdp_array
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  slot_e                   slot,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (slot == SLOT_WRITE && !mask[g])
        store[addr] <= wdata[g*LANE_W +: LANE_W];
      if (slot == SLOT_READ)
        rd_q <= store[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sdp_out_pipe.sv
module sdp_out_pipe
  import sdp_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke,
  input  logic [1:0]              lat_sel,
  input  logic                    issue,
  input  logic                    flush,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] rd_word,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        oe
);

  localparam int DW = LANES * LANE_W;

  logic [MAX_LAT-1:0] vld_q;
  logic [DW-1:0]      dat [MAX_LAT];
  logic [LANES-1:0]   msk1_q, msk2_q;
  logic [1:0]         tap;

  assign dat[0] = rd_word;

  always_ff @(posedge clk) begin
    if (rst) vld_q[0] <= 1'b0;
    else if (cke) vld_q[0] <= issue && !flush;
  end

  for (genvar s = 1; s < MAX_LAT; s++) begin : g_stage
    logic [DW-1:0] dat_q;
    always_ff @(posedge clk) begin
      if (rst) vld_q[s] <= 1'b0;
      else if (cke) vld_q[s] <= flush ? 1'b0 : vld_q[s-1];
    end
    always_ff @(posedge clk) begin
      if (cke) dat_q <= dat[s-1];
    end
    assign dat[s] = dat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msk1_q <= '0;
      msk2_q <= '0;
    end else if (cke) begin
      msk1_q <= mask;
      msk2_q <= msk1_q;
    end
  end

  assign tap = lat_decode(lat_sel) - 2'd1;

  for (genvar g = 0; g < LANES; g++) begin : g_drive
    assign oe[g] = vld_q[tap] && !msk2_q[g];
    assign dout[g*LANE_W +: LANE_W] = oe[g] ? dat[tap][g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sdram_rdlat_pipe.sv
module sdram_rdlat_pipe
  import sdp_pkg::*;
#(
  parameter int BANK_W    = 1,
  parameter int COL_W     = 8,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke,
  input  logic [1:0]              lat_sel,
  input  logic                    rd_cmd,
  input  logic                    wr_cmd,
  input  logic                    pre_cmd,
  input  logic [BANK_W-1:0]       bank,
  input  logic [COL_W-1:0]        col,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        oe
);

  localparam int ADDR_W = BANK_W + COL_W;
  localparam int DW     = LANES * LANE_W;

  slot_e             slot;
  logic [ADDR_W-1:0] slot_addr;
  logic              flush;
  logic [DW-1:0]     rd_word;

  sdp_burst_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_seq (
    .clk(clk), .rst(rst), .cke(cke),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd),
    .cmd_addr({bank, col}),
    .slot(slot), .slot_addr(slot_addr), .flush(flush)
  );

  sdp_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .slot(slot), .addr(slot_addr),
    .mask(mask), .wdata(din), .rdata(rd_word)
  );

  sdp_out_pipe #(.LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk(clk), .rst(rst), .cke(cke), .lat_sel(lat_sel),
    .issue(slot == SLOT_READ), .flush(flush),
    .mask(mask), .rd_word(rd_word),
    .dout(dout), .oe(oe)
  );

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cke,
  input logic [1:0]              lat_sel,
  input logic                    rd_cmd,
  input logic                    wr_cmd,
  input logic                    pre_cmd,
  input logic [LANES-1:0]        mask,
  input logic [LANES*LANE_W-1:0] dout,
  input logic [LANES-1:0]        oe
);

  // R8: a write edge leaves no read word on the bus
  a_r8_write_clears_bus: assert property (@(posedge clk) disable iff (rst)
    (cke && wr_cmd && !rd_cmd) |=> (oe == '0));

  // R10: a low clock enable holds the bus
  a_r10_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    !cke |=> (!$stable(lat_sel) || ($stable(oe) && $stable(dout))));

  // R5: lane mask blanks the lane two enabled edges later
  a_r5_mask_low_lane: assert property (@(posedge clk) disable iff (rst)
    (cke && $past(cke && mask[0] && !rst)) |=> !oe[0]);

  a_r5_mask_high_lane: assert property (@(posedge clk) disable iff (rst)
    (cke && $past(cke && mask[LANES-1] && !rst)) |=> !oe[LANES-1]);

  // R6: bus idle by the third enabled edge after a precharge
  a_r6_precharge_idle: assert property (@(posedge clk) disable iff (rst)
    (cke && !rd_cmd && $past(cke && !rd_cmd && !rst)
     && $past(cke && pre_cmd && !rd_cmd && !wr_cmd && !rst, 2)) |=> (oe == '0));

  // R9: a read right after a write does not drive before its latency
  a_r9_read_after_write: assert property (@(posedge clk) disable iff (rst)
    (cke && rd_cmd && lat_sel >= 2'd2 && $past(cke && wr_cmd && !rd_cmd && !rst))
    |=> (oe == '0));

endmodule

bind sdram_rdlat_pipe sdp_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .lat_sel(lat_sel),
  .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd),
  .mask(mask), .dout(dout), .oe(oe)
);

// File: tb/sdram_rdlat_pipe_test.sv
module sdram_rdlat_pipe_test;

  localparam int BL = 4;
  localparam int NE = 1024;

  logic        clk = 0;
  logic        rst = 1;
  logic        cke = 1;
  logic [1:0]  lat_sel = 2'd1;
  logic        rd_cmd = 0, wr_cmd = 0, pre_cmd = 0;
  logic [0:0]  bank = 0;
  logic [7:0]  col = 0;
  logic [1:0]  mask = 0;
  logic [15:0] din = 0;
  logic [15:0] dout;
  logic [1:0]  oe;

  sdram_rdlat_pipe uut (
    .clk(clk), .rst(rst), .cke(cke), .lat_sel(lat_sel),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd),
    .bank(bank), .col(col), .mask(mask), .din(din),
    .dout(dout), .oe(oe)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [15:0] refmem [512];
  logic        sv [NE];
  logic [15:0] sd [NE];
  logic [1:0]  mh [NE];
  int ecnt = 2;
  bit act = 0, isrd = 0;
  int rem = 0, a = 0;

  always @(posedge clk) begin
    int e, lat, kind;
    logic [1:0] eo;
    logic [15:0] ed;
    cycles++;
    if (rst) begin
      for (int t = 0; t < NE; t++) begin sv[t] = 0; mh[t] = 0; end
      act = 0; ecnt = 2;
    end else if (cke) begin
      e = ecnt + 1;
      lat = (lat_sel == 2'd2) ? 2 : (lat_sel == 2'd3) ? 3 : 1;
      kind = 0;
      if (rd_cmd) begin
        act = 1; isrd = 1; a = {bank, col}; rem = BL - 1; kind = 1;
      end else if (wr_cmd) begin
        for (int t = e; t < NE; t++) sv[t] = 0;
        act = 1; isrd = 0; a = {bank, col}; rem = BL - 1; kind = 2;
      end else if (pre_cmd) begin
        act = 0;
      end else if (act) begin
        a = (a & ~(BL - 1)) | ((a + 1) & (BL - 1));
        rem--;
        if (rem == 0) act = 0;
        kind = isrd ? 1 : 2;
      end
      if (kind == 1) begin
        sv[e + lat - 1] = 1;
        sd[e + lat - 1] = refmem[a];
      end else if (kind == 2) begin
        if (!mask[0]) refmem[a][7:0]  = din[7:0];
        if (!mask[1]) refmem[a][15:8] = din[15:8];
      end
      mh[e] = mask;
      ecnt = e;
    end
    #3;
    eo[0] = sv[ecnt] && !mh[ecnt-1][0];
    eo[1] = sv[ecnt] && !mh[ecnt-1][1];
    ed = {eo[1] ? sd[ecnt][15:8] : 8'h00, eo[0] ? sd[ecnt][7:0] : 8'h00};
    total++;
    if (oe !== eo || dout !== ed) begin
      bad++;
      $display("FAIL %s at cycle %0d: oe=%b dout=%h expected oe=%b dout=%h",
               cur_req, cycles, oe, dout, eo, ed);
    end
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input bit r, input bit w, input bit p, input int adr,
                      input logic [1:0] m, input logic [15:0] d);
    rd_cmd = r; wr_cmd = w; pre_cmd = p;
    bank = adr[8]; col = adr[7:0]; mask = m; din = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'b00, 16'h0);
  endtask

  task automatic wr_burst(input int adr, input logic [15:0] base, input logic [7:0] mpat);
    step(0, 1, 0, adr, mpat[1:0], base);
    for (int i = 1; i < BL; i++) step(0, 0, 0, 0, mpat[2*i +: 2], base + 16'(i));
  endtask

  task automatic rd_at(input int adr, input logic [1:0] lat);
    lat_sel = lat;
    step(1, 0, 0, adr, 2'b00, 16'h0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    cur_req = "R1"; idle(3);

    cur_req = "R4";
    wr_burst(0,   16'hA000, 8'h00);
    wr_burst(260, 16'hB000, 8'h00);
    wr_burst(8,   16'hC000, 8'h00);
    wr_burst(10,  16'hD000, 8'b00_10_01_00);
    wr_burst(16,  16'h6600, 8'h00);
    wr_burst(20,  16'h9000, 8'h00);
    idle(2);

    cur_req = "R2"; rd_at(0, 2'd1);   idle(6);
    cur_req = "R2"; rd_at(260, 2'd2); idle(6);
    cur_req = "R2"; rd_at(8, 2'd3);   idle(6);
    cur_req = "R2"; rd_at(4, 2'd0);   idle(6);
    cur_req = "R3"; rd_at(10, 2'd2);  idle(6);
    cur_req = "R4"; rd_at(8, 2'd1);   idle(6);

    cur_req = "R5"; rd_at(0, 2'd2);
    step(0, 0, 0, 0, 2'b01, 16'h0);
    step(0, 0, 0, 0, 2'b10, 16'h0);
    step(0, 0, 0, 0, 2'b11, 16'h0);
    idle(6);

    cur_req = "R6"; rd_at(0, 2'd3);
    idle(1);
    step(0, 0, 1, 0, 2'b00, 16'h0);
    idle(6);
    cur_req = "R6"; rd_at(8, 2'd1);
    step(0, 0, 1, 0, 2'b00, 16'h0);
    idle(5);

    cur_req = "R7"; rd_at(0, 2'd2);
    idle(1);
    step(1, 0, 0, 260, 2'b00, 16'h0);
    idle(7);

    cur_req = "R8"; rd_at(0, 2'd3);
    idle(1);
    wr_burst(16, 16'hE000, 8'h00);
    idle(4);
    rd_at(16, 2'd1); idle(6);

    cur_req = "R9";
    lat_sel = 2'd2;
    step(0, 1, 0, 20, 2'b00, 16'h5550);
    step(1, 0, 0, 0, 2'b00, 16'h5551);
    idle(6);
    rd_at(20, 2'd3); idle(6);

    cur_req = "R10"; rd_at(8, 2'd2);
    idle(1);
    cke = 0;
    step(0, 1, 0, 8, 2'b11, 16'hFFFF);
    step(1, 0, 0, 0, 2'b11, 16'h0);
    step(0, 0, 1, 0, 2'b11, 16'h0);
    cke = 1;
    idle(6);
    rd_at(8, 2'd1); idle(6);

    cur_req = "R11";
    lat_sel = 2'd1;
    step(1, 1, 1, 260, 2'b00, 16'h1234);
    idle(6);
    step(0, 1, 1, 24, 2'b00, 16'h7770);
    idle(4);
    rd_at(24, 2'd2); idle(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule